// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block is a slave stereo serial audio port. An external device drives the bit clock and the word-select line. Every signal on the port is oversampled in the block's own clock domain. The receive path collects each left and right input word from the serial input pin. When a frame is complete, it presents both words as left-aligned 24-bit parallel samples together with a one-cycle valid strobe. The transmit path captures a pair of parallel samples once per frame and shifts them out on the serial output pin.

A 3-bit format code selects the word alignment: I2S, MSB-justified, or LSB-justified with 16, 18 or 20 bits. The receive and transmit paths decode the code independently. In the mixed codes the serial output is MSB-justified while the serial input stays LSB-justified. Input bits are taken on rising bit-clock edges. Output bits change only after falling bit-clock edges. The driver of the port keeps word select changing on falling edges, and the bit clock runs at no more than 128 times the word-select rate.

Top module: `audio_port`

## Requirements
- R1: Code 000 receives I2S. Word select low marks the left word. The MSB is the bit taken on the second rising bit-clock edge after a word-select change, and up to 24 bits are taken, all on rising edges.
- R2: Code 100 receives MSB-justified words. The MSB is the bit taken on the first rising edge after a word-select change.
- R3: Codes 001/101, 010/110 and 011/111 receive LSB-justified words of 16, 18 and 20 bits. The last bit is the one taken on the final rising edge before word select changes. The word is placed in the top bits of the 24-bit output, and the remaining low bits are zero.
- R4: If an MSB-justified half-frame is shorter than 24 bit clocks, only the bits actually received fill the top of the output word. The rest of the word is zero.
- R5: rx_valid_o pulses for one clock cycle once per frame, after the right word has completed. rx_left_o and rx_right_o change only together with that pulse. No pulse is produced until a complete left half-frame has been seen after reset.
- R6: On the transmit side, 000 sends I2S (MSB on the second rising edge after the change) and 100 to 111 send MSB-justified words (MSB on the first rising edge). sdout_o changes only after a falling bit-clock edge. Bits beyond the word length are sent as 0.
- R7: Transmit codes 001, 010 and 011 send the top 16, 18 or 20 bits of the parallel word. The last bit falls on the final bit clock before word select changes, and the position is taken from the length of the preceding half-frame.
- R8: tx_load_o pulses once per frame, at the falling edge where word select goes low. That edge captures both parallel words and the transmit format. Later changes to those inputs do not alter the frame in flight.
- R9: During reset, rx_valid_o, tx_load_o, sdout_o and both received words are zero.
- R10: Half-frames of up to 64 bit clocks (128 bit clocks per frame) are handled in every format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial port |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select, low for left |
| sdin_i | input | 1 | Serial input data |
| fmt_i | input | 3 | Format code |
| tx_left_i | input | 24 | Left sample to transmit |
| tx_right_i | input | 24 | Right sample to transmit |
| tx_load_o | output | 1 | Pulse when the transmit samples are captured |
| sdout_o | output | 1 | Serial output data |
| rx_left_o | output | 24 | Received left sample, left-aligned |
| rx_right_o | output | 24 | Received right sample, left-aligned |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
Every one of the eight format codes is driven with distinct left and right words, including words with a lone set MSB or LSB, alternating bits and inverted pairs. These patterns expose a receive or transmit alignment that is off by one clock, a swapped channel, and a wrong LSB width. Half-frames of 32 bit clocks exercise the normal case. Short 20-clock half-frames separate correct zero padding from stale data and check LSB timing against a short frame. Long 64-clock half-frames catch counter saturation and window-edge faults. The transmit words are inverted in the middle of each frame, which shows that the samples are captured once at the left-half boundary.

// File: rtl/ap_pkg.sv
package ap_pkg;

    typedef enum logic [1:0] {
        ALN_I2S = 2'd0,
        ALN_MSB = 2'd1,
        ALN_LSB = 2'd2
    } align_e;

    typedef struct packed {
        align_e     aln;
        logic [4:0] len;
    } fmt_t;

    // Receive-side decode: LSB width comes from the two low code bits.
    function automatic fmt_t rx_format(input logic [2:0] code);
        fmt_t f;
        f.aln = ALN_LSB;
        case (code[1:0])
            2'b01:   f.len = 5'd16;
            2'b10:   f.len = 5'd18;
            2'b11:   f.len = 5'd20;
            default: f.len = 5'd24;
        endcase
        if (code == 3'b000)      f.aln = ALN_I2S;
        else if (code == 3'b100) f.aln = ALN_MSB;
        return f;
    endfunction

    // Transmit-side decode: the upper half of the code space is MSB-justified.
    function automatic fmt_t tx_format(input logic [2:0] code);
        fmt_t f;
        f = rx_format(code);
        if (code[2]) begin
            f.aln = ALN_MSB;
            f.len = 5'd24;
        end
        return f;
    endfunction

endpackage

// File: rtl/ap_edge.sv
module ap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic rise_o,
    output logic fall_o,
    output logic ws_o,
    output logic sd_o
);
    localparam int W = 3;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic                     bclk_last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = {bclk_i, ws_i, sd_i};
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.bclk_last = st_q.pipe[STAGES-1][2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.pipe[STAGES-1][2] & ~st_q.bclk_last;
    assign fall_o = ~st_q.pipe[STAGES-1][2] & st_q.bclk_last;
    assign ws_o   = st_q.pipe[STAGES-1][1];
    assign sd_o   = st_q.pipe[STAGES-1][0];
endmodule

// File: rtl/ap_rx.sv
module ap_rx
    import ap_pkg::*;
#(
    parameter int SW    = 24,
    parameter int HW    = 64,
    localparam int CW   = $clog2(HW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_i,
    input  logic          ws_i,
    input  logic          din_i,
    input  logic [2:0]    fmt_i,
    output logic [SW-1:0] left_o,
    output logic [SW-1:0] right_o,
    output logic          valid_o
);
    typedef struct packed {
        logic [HW-1:0] hist;
        logic [CW-1:0] cnt;
        logic          ws;
        logic          primed;
        logic          started;
        logic          left_ok;
        fmt_t          fmt;
        logic [SW-1:0] left;
        logic [SW-1:0] out_l;
        logic [SW-1:0] out_r;
        logic          valid;
    } rx_st_t;

    rx_st_t st_d, st_q;

    logic [HW-1:0] src;
    logic [HW-1:0] aligned;
    logic [SW-1:0] low_bits;
    logic [SW-1:0] word;

    // Word extraction from the history window of the half just ended.
    always_comb begin
        src      = (st_q.fmt.aln == ALN_I2S) ? {st_q.hist[HW-2:0], din_i} : st_q.hist;
        aligned  = src << (CW'(HW) - st_q.cnt);
        low_bits = st_q.hist[SW-1:0] << (SW - int'(st_q.fmt.len));
        word     = (st_q.fmt.aln == ALN_LSB) ? low_bits : aligned[HW-1 -: SW];
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (rise_i) begin
            st_d.hist = {st_q.hist[HW-2:0], din_i};
            if (!st_q.primed) begin
                st_d.primed = 1'b1;
                st_d.ws     = ws_i;
                st_d.cnt    = CW'(1);
            end else if (ws_i != st_q.ws) begin
                if (st_q.started) begin
                    if (!st_q.ws) begin
                        st_d.left    = word;
                        st_d.left_ok = 1'b1;
                    end else if (st_q.left_ok) begin
                        st_d.out_l   = st_q.left;
                        st_d.out_r   = word;
                        st_d.valid   = 1'b1;
                        st_d.left_ok = 1'b0;
                    end
                end
                st_d.started = 1'b1;
                st_d.ws      = ws_i;
                st_d.cnt     = CW'(1);
                st_d.fmt     = rx_format(fmt_i);
            end else if (st_q.cnt != CW'(HW)) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o  = st_q.out_l;
    assign right_o = st_q.out_r;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/ap_tx.sv
module ap_tx
    import ap_pkg::*;
#(
    parameter int SW    = 24,
    parameter int HW    = 64,
    localparam int CW   = $clog2(HW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_i,
    input  logic          ws_i,
    input  logic [2:0]    fmt_i,
    input  logic [SW-1:0] left_i,
    input  logic [SW-1:0] right_i,
    output logic          sdout_o,
    output logic          load_o
);
    typedef struct packed {
        logic          ws;
        logic          primed;
        logic          started;
        logic [CW-1:0] fcnt;
        logic [CW-1:0] nlen;
        fmt_t          fmt;
        logic [SW-1:0] hold_l;
        logic [SW-1:0] hold_r;
        logic          sdout;
        logic          load;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        int            f;
        int            n;
        int            l;
        int            idx;
        logic          ok;
        logic [SW-1:0] w;
        logic [SW-1:0] sh;

        st_d      = st_q;
        st_d.load = 1'b0;
        f = 0; n = 0; l = 0; idx = 0; ok = 1'b0; w = '0; sh = '0;
        if (fall_i) begin
            if (!st_q.primed) begin
                st_d.primed = 1'b1;
                st_d.ws     = ws_i;
                st_d.fcnt   = CW'(HW - 1);
            end else if (ws_i != st_q.ws) begin
                st_d.ws      = ws_i;
                st_d.fcnt    = '0;
                st_d.nlen    = st_q.fcnt + CW'(1);
                st_d.started = 1'b1;
                if (!ws_i) begin
                    st_d.hold_l = left_i;
                    st_d.hold_r = right_i;
                    st_d.fmt    = tx_format(fmt_i);
                    st_d.load   = 1'b1;
                end
            end else if (st_q.fcnt != CW'(HW - 1)) begin
                st_d.fcnt = st_q.fcnt + CW'(1);
            end

            // The bit driven now is taken on rising edge fcnt+1 of the half.
            f = int'(st_d.fcnt);
            n = int'(st_d.nlen);
            l = int'(st_d.fmt.len);
            case (st_d.fmt.aln)
                ALN_I2S: begin
                    ok  = (f >= 1) && (f <= SW);
                    idx = SW - f;
                end
                ALN_MSB: begin
                    ok  = (f < SW);
                    idx = SW - 1 - f;
                end
                default: begin
                    ok  = (f < n) && ((n - 1 - f) < l);
                    idx = SW - l + (n - 1 - f);
                end
            endcase
            w = st_d.ws ? st_d.hold_r : st_d.hold_l;
            if (st_d.started && ok) begin
                sh         = w >> idx;
                st_d.sdout = sh[0];
            end else begin
                st_d.sdout = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdout_o = st_q.sdout;
    assign load_o  = st_q.load;
endmodule

// File: rtl/audio_port.sv
module audio_port #(
    parameter int SAMPLE_W    = 24,
    parameter int MAX_HALF    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                ws_i,
    input  logic                sdin_i,
    input  logic [2:0]          fmt_i,
    input  logic [SAMPLE_W-1:0] tx_left_i,
    input  logic [SAMPLE_W-1:0] tx_right_i,
    output logic                tx_load_o,
    output logic                sdout_o,
    output logic [SAMPLE_W-1:0] rx_left_o,
    output logic [SAMPLE_W-1:0] rx_right_o,
    output logic                rx_valid_o
);
    logic rise_w;
    logic fall_w;
    logic ws_w;
    logic din_w;

    ap_edge #(.STAGES(SYNC_STAGES)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_i (bclk_i),
        .ws_i   (ws_i),
        .sd_i   (sdin_i),
        .rise_o (rise_w),
        .fall_o (fall_w),
        .ws_o   (ws_w),
        .sd_o   (din_w)
    );

    ap_rx #(.SW(SAMPLE_W), .HW(MAX_HALF)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_w),
        .ws_i    (ws_w),
        .din_i   (din_w),
        .fmt_i   (fmt_i),
        .left_o  (rx_left_o),
        .right_o (rx_right_o),
        .valid_o (rx_valid_o)
    );

    ap_tx #(.SW(SAMPLE_W), .HW(MAX_HALF)) i_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall_w),
        .ws_i    (ws_w),
        .fmt_i   (fmt_i),
        .left_i  (tx_left_i),
        .right_i (tx_right_i),
        .sdout_o (sdout_o),
        .load_o  (tx_load_o)
    );
endmodule

// File: rtl/audio_port_checker.sv
module audio_port_checker #(
    parameter int SW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rise_w,
    input logic          fall_w,
    input logic          rx_valid_o,
    input logic [SW-1:0] rx_left_o,
    input logic [SW-1:0] rx_right_o,
    input logic          sdout_o,
    input logic          tx_load_o
);
    // R5: the received-pair strobe lasts a single cycle.
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R5: received words only move together with the strobe.
    a_r5_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> ($stable(rx_left_o) && $stable(rx_right_o)));

    // R1: a completed pair follows a rising bit-clock edge.
    a_r1_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(rise_w));

    // R6: serial output moves only after a falling bit-clock edge.
    a_r6_sdout_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout_o) |-> $past(fall_w));

    // R8: capture happens on a falling edge and lasts one cycle.
    a_r8_load_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> $past(fall_w));

    a_r8_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |=> !tx_load_o);
endmodule

bind audio_port audio_port_checker #(.SW(SAMPLE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_w     (rise_w),
    .fall_w     (fall_w),
    .rx_valid_o (rx_valid_o),
    .rx_left_o  (rx_left_o),
    .rx_right_o (rx_right_o),
    .sdout_o    (sdout_o),
    .tx_load_o  (tx_load_o)
);

// File: tb/test_audio_port.sv
module test_audio_port;
    localparam int H = 6;   // block-clock cycles per bit-clock phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        ws = 1'b1;
    logic        sdin = 1'b0;
    logic [2:0]  fmt = 3'b000;
    logic [23:0] txl = '0;
    logic [23:0] txr = '0;
    logic        tx_load_o;
    logic        sdout_o;
    logic [23:0] rx_left_o;
    logic [23:0] rx_right_o;
    logic        rx_valid_o;

    always #2 clk = ~clk;

    audio_port i_audio_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_i     (bclk),
        .ws_i       (ws),
        .sdin_i     (sdin),
        .fmt_i      (fmt),
        .tx_left_i  (txl),
        .tx_right_i (txr),
        .tx_load_o  (tx_load_o),
        .sdout_o    (sdout_o),
        .rx_left_o  (rx_left_o),
        .rx_right_o (rx_right_o),
        .rx_valid_o (rx_valid_o)
    );

    typedef struct {
        bit          chk;
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   n_load = 0;
    int   n_valid = 0;
    int   n_frames = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // kind 0 = I2S, 1 = MSB-justified, 2 = LSB-justified
    function automatic void decode(input logic [2:0] c, input bit tx,
                                   output int k, output int l);
        l = (c[1:0] == 2'b01) ? 16 : (c[1:0] == 2'b10) ? 18 : (c[1:0] == 2'b11) ? 20 : 24;
        if (c == 3'b000)           k = 0;
        else if (c == 3'b100)      k = 1;
        else if (tx && c[2])       begin k = 1; l = 24; end
        else                       k = 2;
    endfunction

    // Bit carried on rising edge r (1-based) of an n-clock half.
    function automatic logic exp_bit(input int k, input int l, input int n,
                                     input int r, input logic [23:0] w);
        if (k == 0)      return (r >= 2 && r <= 25) ? w[25-r] : 1'b0;
        else if (k == 1) return (r <= 24) ? w[24-r] : 1'b0;
        else             return (r > n - l) ? w[24-l+n-r] : 1'b0;
    endfunction

    function automatic logic [23:0] exp_word(input int k, input int l, input int n,
                                             input logic [23:0] w);
        if (k == 0)      return w;
        else if (k == 1) return (n >= 24) ? w : (w & ~(24'hFFFFFF >> n));
        else             return w & ~(24'hFFFFFF >> l);
    endfunction

    // Scoreboard monitor for received pairs.
    always @(negedge clk) begin : rx_monitor
        exp_t e;
        if (rst_n && rx_valid_o) begin
            n_valid++;
            if (sbq.size() == 0) begin
                check(1'b0, "R5", "strobe with no frame pending", 64'(rx_left_o), 64'd0);
            end else begin
                e = sbq.pop_front();
                if (e.chk) begin
                    check(rx_left_o === e.l, e.tag, "left word", 64'(rx_left_o), 64'(e.l));
                    check(rx_right_o === e.r, e.tag, "right word", 64'(rx_right_o), 64'(e.r));
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && tx_load_o) n_load++;
    end

    task automatic run_half(input logic wsv, input int n,
                            input int rk, input int rl, input logic [23:0] w,
                            input int tk, input int tl, input logic [23:0] tw,
                            input bit chk_tx, input string ttag, input bit hook);
        logic [63:0] gv;
        logic [63:0] ev;
        int          loads0;
        gv = '0;
        ev = '0;
        loads0 = n_load;
        for (int r = 1; r <= n; r++) begin
            @(negedge clk);
            bclk = 1'b0;
            ws   = wsv;
            sdin = exp_bit(rk, rl, n, r, w);
            repeat (H) @(negedge clk);
            gv = {gv[62:0], sdout_o};
            ev = {ev[62:0], exp_bit(tk, tl, n, r, tw)};
            bclk = 1'b1;
            if (hook && r == 1) begin
                check(n_load == loads0 + 1, "R8", "one capture at left start",
                      64'(n_load - loads0), 64'd1);
                txl = ~txl;
                txr = ~txr;
            end
            repeat (H - 1) @(negedge clk);
        end
        if (chk_tx) check(gv === ev, ttag, "serial output half", gv, ev);
    endtask

    task automatic frame(input logic [2:0] code, input int n,
                         input logic [23:0] l, input logic [23:0] r,
                         input logic [23:0] tl, input logic [23:0] tr,
                         input bit chk_rx, input bit chk_tx);
        int    rk, rl, tk, tlen;
        exp_t  e;
        string rtag, ttag;
        decode(code, 1'b0, rk, rl);
        decode(code, 1'b1, tk, tlen);
        rtag = (rk == 0) ? "R1" : (rk == 1) ? ((n < 24) ? "R4" : "R2") : "R3";
        ttag = (tk == 2) ? "R7 R8" : "R6 R8";
        if (n == 64) begin
            rtag = {rtag, " R10"};
            ttag = {ttag, " R10"};
        end
        e.chk = chk_rx;
        e.l   = exp_word(rk, rl, n, l);
        e.r   = exp_word(rk, rl, n, r);
        e.tag = rtag;
        sbq.push_back(e);
        @(negedge clk);
        fmt = code;
        txl = tl;
        txr = tr;
        run_half(1'b0, n, rk, rl, l, tk, tlen, tl, chk_tx, ttag, 1'b1);
        run_half(1'b1, n, rk, rl, r, tk, tlen, tr, chk_tx, ttag, 1'b0);
        n_frames++;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R9: reset state
        check({rx_valid_o, tx_load_o, sdout_o} === 3'b000, "R9", "strobes and serial out in reset",
              64'({rx_valid_o, tx_load_o, sdout_o}), 64'd0);
        check({rx_left_o, rx_right_o} === 48'd0, "R9", "received words in reset",
              64'({rx_left_o, rx_right_o}), 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Preamble right half so the first left half starts cleanly.
        run_half(1'b1, 32, 1, 24, 24'h0, 1, 24, 24'h0, 1'b0, "", 1'b0);

        frame(3'b000, 32, 24'h800001, 24'h7FFFFE, 24'h123456, 24'hFEDCBA, 1'b1, 1'b0);
        frame(3'b000, 32, 24'hA5C3F1, 24'h5A3C0E, 24'h800001, 24'h000001, 1'b1, 1'b1);
        frame(3'b100, 32, 24'h123456, 24'hFEDCBA, 24'hAAAAAA, 24'h555555, 1'b1, 1'b1);
        frame(3'b100, 32, 24'h000001, 24'h800000, 24'hC0FFEE, 24'h3F0011, 1'b1, 1'b1);
        frame(3'b001, 32, 24'hABCDEF, 24'h13579B, 24'h8001FF, 24'hFF0180, 1'b1, 1'b1);
        frame(3'b010, 32, 24'hFFFFC0, 24'h00C000, 24'h24680A, 24'hDB97F5, 1'b1, 1'b1);
        frame(3'b011, 32, 24'h0F0F0F, 24'hF0F0F0, 24'h00001F, 24'hFFF000, 1'b1, 1'b1);
        frame(3'b101, 32, 24'hBEEF00, 24'h0100FF, 24'h808080, 24'h7F7F7F, 1'b1, 1'b1);
        frame(3'b110, 32, 24'h3FFFC0, 24'hC00040, 24'h13ACE0, 24'hEC531F, 1'b1, 1'b1);
        frame(3'b111, 32, 24'hFEDCBA, 24'h000010, 24'h0A0B0C, 24'hF5F4F3, 1'b1, 1'b1);
        // Short half-frames
        frame(3'b100, 20, 24'hFFFFFF, 24'h9ABCDE, 24'hFFFFFF, 24'h112233, 1'b1, 1'b0);
        frame(3'b100, 20, 24'h87654F, 24'h0000F0, 24'h89ABCD, 24'h765432, 1'b1, 1'b1);
        frame(3'b001, 20, 24'hCAFE12, 24'h1234FF, 24'hF00F77, 24'h0FF088, 1'b1, 1'b1);
        // Longest half-frames
        frame(3'b011, 64, 24'h96A5F3, 24'h0000F1, 24'h55AA55, 24'hAA55AA, 1'b1, 1'b0);
        frame(3'b011, 64, 24'hE1E2E3, 24'h1E2E3E, 24'h000FFF, 24'hFFF000, 1'b1, 1'b1);
        frame(3'b000, 64, 24'hC3A501, 24'h800000, 24'hB00B1E, 24'h4FF4E1, 1'b1, 1'b1);

        // Start of one more left half completes the last right word.
        run_half(1'b0, 4, 1, 24, 24'h0, 1, 24, 24'h0, 1'b0, "", 1'b0);
        repeat (40) @(negedge clk);
        check(sbq.size() == 0, "R5", "every frame produced a strobe", 64'(sbq.size()), 64'd0);
        check(n_valid == n_frames, "R5", "one strobe per frame", 64'(n_valid), 64'(n_frames));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule